// File: doc/BRIEF.md
# Fully Associative Page Translation Buffer

This block holds a small set of recently used virtual-to-physical page mappings and answers translation lookups from them. Each stored mapping carries a validity flag, the virtual page tag, the physical page number and four permission flags: read, write, execute and dirty. A lookup compares the requested virtual page number against every valid mapping at once. On a hit the physical page number and the permission flags are returned on the next cycle. On a miss the block asks an external page table walker for the mapping, installs the entry that comes back and then repeats the lookup internally before answering.

Software keeps the buffer coherent with memory in two ways: a flush pulse, issued whenever the page table base register is written, drops every mapping; an invalidate pulse with a virtual page number drops only that page's mapping after a table entry is edited. The buffer never writes anything back to memory. A store that hits a mapping whose dirty flag is clear is treated as a miss, so the walker can mark the page dirty in memory and return a refreshed mapping, which overwrites the old one in place.

The controller is a three-state machine. `ST_IDLE` accepts requests; a request that misses moves it to `ST_WALK` (transition *miss*), where it waits for the walker's reply; the reply moves it to `ST_RETRY` (transition *install*); the repeated lookup returns to `ST_IDLE` when it hits (transition *answer*) or back to `ST_WALK` when the installed entry was dropped in the meantime (transition *rewalk*).

Top module: `xlat_buf`

## Requirements
- R1: After reset no mapping is valid, `req_ready_o` is 1, and `fill_req_o` and `rsp_valid_o` are 0; the first lookup of any page therefore misses.
- R2: A lookup accepted at a clock edge (`req_valid_i` with `req_ready_o`) whose page is present and allowed answers after that same edge with `rsp_valid_o` = 1, the stored page number and the stored permission flags, and raises no walk request. Permission bits are `[0]` read, `[1]` write, `[2]` execute, `[3]` dirty.
- R3: A lookup that misses raises `fill_req_o` after its accepting edge with `fill_vpn_o` equal to the requested page; both hold until `fill_valid_i` is seen, and `req_ready_o` stays 0 meanwhile.
- R4: The mapping given with `fill_valid_i` is installed at that edge; the internal repeat lookup answers one edge later with exactly the page number and flags that were supplied.
- R5: A store (`req_write_i` = 1) that hits a mapping with dirty = 0 is handled as a miss; the refill overwrites that same entry, so no other mapping is evicted. A store that hits a dirty mapping is an ordinary hit.
- R6: A refill goes into the lowest-numbered invalid entry if any; otherwise it replaces the least recently used entry, where both hits and installs count as uses.
- R7: A `flush_i` pulse leaves no mapping valid after that edge.
- R8: An `inv_valid_i` pulse removes only the mapping whose tag equals `inv_vpn_i`; all other mappings stay and still hit.
- R9: A flush, or an invalidate of the same page, in the same cycle as `fill_valid_i` wins: the installed entry is dropped, the repeat lookup misses and `fill_req_o` is raised again for the same page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Lookup request |
| req_vpn_i | input | VPN_W | Virtual page number to translate |
| req_write_i | input | 1 | Request is a store |
| req_ready_o | output | 1 | Block can accept a lookup this cycle |
| rsp_valid_o | output | 1 | Translation answer valid |
| rsp_ppn_o | output | PPN_W | Physical page number of the answer |
| rsp_perm_o | output | 4 | Flags of the answer: read, write, execute, dirty (bit 0 to 3) |
| fill_req_o | output | 1 | Walk request to the page table walker |
| fill_vpn_o | output | VPN_W | Page the walker must fetch |
| fill_valid_i | input | 1 | Walker reply valid |
| fill_ppn_i | input | PPN_W | Physical page number from the walker |
| fill_perm_i | input | 4 | Flags from the walker, same bit order |
| flush_i | input | 1 | Drop every mapping |
| inv_valid_i | input | 1 | Drop one mapping |
| inv_vpn_i | input | VPN_W | Page whose mapping is dropped |

## Verification
The assertions assume the walker only drives `fill_valid_i` while `fill_req_o` is high, and that a walker answering a store returns the dirty flag set, so the repeat lookup cannot loop. The bench's walker model replies exactly one cycle after each request it sees and always sets dirty for stores. Flush and invalidate pulses are issued either while the block is idle with no request pending or deliberately in the reply cycle, never alongside a fresh request, so the assertions about cleared entries see a stable picture.

// File: rtl/xb_pkg.sv
package xb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WALK  = 2'd1,
        ST_RETRY = 2'd2
    } xb_state_e;

    typedef struct packed {
        logic d;
        logic x;
        logic w;
        logic r;
    } xb_perm_t;

endpackage

// File: rtl/xb_match.sv
module xb_match #(
    parameter int N     = 64,
    parameter int TAG_W = 20,
    parameter int IDX_W = 6
) (
    input  logic [N-1:0]     valid_i,
    input  logic [TAG_W-1:0] tags_i [N],
    input  logic [TAG_W-1:0] key_i,
    output logic [N-1:0]     match_o,
    output logic             hit_o,
    output logic [IDX_W-1:0] idx_o
);

    always_comb begin
        idx_o = '0;
        for (int i = 0; i < N; i++) begin
            match_o[i] = valid_i[i] && (tags_i[i] == key_i);
            if (match_o[i]) idx_o = idx_o | IDX_W'(i);
        end
        hit_o = |match_o;
    end

endmodule

// File: rtl/xb_lru.sv
module xb_lru #(
    parameter int N     = 64,
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             touch_en_i,
    input  logic [IDX_W-1:0] touch_idx_i,
    input  logic [N-1:0]     valid_i,
    output logic [IDX_W-1:0] victim_o
);

    localparam logic [IDX_W-1:0] OLDEST = IDX_W'(N - 1);

    logic [IDX_W-1:0] age_q [N];
    logic [IDX_W-1:0] touched_age;
    logic [IDX_W-1:0] free_idx;
    logic [IDX_W-1:0] old_idx;
    logic             any_free;

    assign touched_age = age_q[touch_idx_i];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) age_q[i] <= IDX_W'(i);
        end else if (touch_en_i) begin
            for (int i = 0; i < N; i++) begin
                if (IDX_W'(i) == touch_idx_i) age_q[i] <= '0;
                else if (age_q[i] < touched_age) age_q[i] <= age_q[i] + 1'b1;
            end
        end
    end

    always_comb begin
        free_idx = '0;
        any_free = 1'b0;
        old_idx  = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!valid_i[i]) begin
                free_idx = IDX_W'(i);
                any_free = 1'b1;
            end
            if (age_q[i] == OLDEST) old_idx = IDX_W'(i);
        end
        victim_o = any_free ? free_idx : old_idx;
    end

    // R6
    touch_young_chk: assert property (@(posedge clk) disable iff (!rst_n)
        touch_en_i |=> age_q[$past(touch_idx_i)] == '0);

endmodule

// File: rtl/xlat_buf.sv
module xlat_buf
    import xb_pkg::*;
#(
    parameter int ENTRIES = 64,
    parameter int VPN_W   = 20,
    parameter int PPN_W   = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid_i,
    input  logic [VPN_W-1:0] req_vpn_i,
    input  logic             req_write_i,
    output logic             req_ready_o,
    output logic             rsp_valid_o,
    output logic [PPN_W-1:0] rsp_ppn_o,
    output logic [3:0]       rsp_perm_o,
    output logic             fill_req_o,
    output logic [VPN_W-1:0] fill_vpn_o,
    input  logic             fill_valid_i,
    input  logic [PPN_W-1:0] fill_ppn_i,
    input  logic [3:0]       fill_perm_i,
    input  logic             flush_i,
    input  logic             inv_valid_i,
    input  logic [VPN_W-1:0] inv_vpn_i
);

    localparam int IDX_W = $clog2(ENTRIES);

    xb_state_e        state_q, state_d;
    logic             valid_q [ENTRIES];
    logic [VPN_W-1:0] tag_q   [ENTRIES];
    logic [PPN_W-1:0] ppn_q   [ENTRIES];
    xb_perm_t         perm_q  [ENTRIES];
    logic [ENTRIES-1:0] valid_vec;

    logic [VPN_W-1:0] hold_vpn_q;
    logic             hold_wr_q;
    logic             rsp_valid_q;
    logic [PPN_W-1:0] rsp_ppn_q;
    xb_perm_t         rsp_perm_q;

    logic [VPN_W-1:0]   key_vpn;
    logic               key_wr;
    logic [ENTRIES-1:0] m_vec;
    logic               m_hit;
    logic [IDX_W-1:0]   m_idx;
    xb_perm_t           sel_perm;
    logic               hit_ok;
    logic               accept, do_lookup, install_en;
    logic [IDX_W-1:0]   victim, slot;
    logic               touch_en;
    logic [IDX_W-1:0]   touch_idx;

    always_comb begin
        for (int i = 0; i < ENTRIES; i++) valid_vec[i] = valid_q[i];
    end

    assign key_vpn    = (state_q == ST_IDLE) ? req_vpn_i   : hold_vpn_q;
    assign key_wr     = (state_q == ST_IDLE) ? req_write_i : hold_wr_q;
    assign accept     = (state_q == ST_IDLE) && req_valid_i;
    assign do_lookup  = accept || (state_q == ST_RETRY);
    assign install_en = (state_q == ST_WALK) && fill_valid_i;

    xb_match #(.N(ENTRIES), .TAG_W(VPN_W), .IDX_W(IDX_W)) u_match (
        .valid_i (valid_vec),
        .tags_i  (tag_q),
        .key_i   (key_vpn),
        .match_o (m_vec),
        .hit_o   (m_hit),
        .idx_o   (m_idx)
    );

    assign sel_perm = perm_q[m_idx];
    assign hit_ok   = m_hit && !(key_wr && !sel_perm.d);
    assign slot     = m_hit ? m_idx : victim;

    assign touch_en  = install_en || (do_lookup && hit_ok);
    assign touch_idx = install_en ? slot : m_idx;

    xb_lru #(.N(ENTRIES), .IDX_W(IDX_W)) u_lru (
        .clk         (clk),
        .rst_n       (rst_n),
        .touch_en_i  (touch_en),
        .touch_idx_i (touch_idx),
        .valid_i     (valid_vec),
        .victim_o    (victim)
    );

    // entry storage; flush and invalidate are applied after an install
    for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
        logic             wr_here;
        logic [VPN_W-1:0] tag_next;
        assign wr_here  = install_en && (slot == IDX_W'(g));
        assign tag_next = wr_here ? hold_vpn_q : tag_q[g];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                valid_q[g] <= 1'b0;
                tag_q[g]   <= '0;
                ppn_q[g]   <= '0;
                perm_q[g]  <= '0;
            end else begin
                if (wr_here) begin
                    tag_q[g]  <= hold_vpn_q;
                    ppn_q[g]  <= fill_ppn_i;
                    perm_q[g] <= xb_perm_t'(fill_perm_i);
                end
                if (flush_i)
                    valid_q[g] <= 1'b0;
                else if (inv_valid_i && (tag_next == inv_vpn_i))
                    valid_q[g] <= 1'b0;
                else if (wr_here)
                    valid_q[g] <= 1'b1;
            end
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_valid_i && !hit_ok) state_d = ST_WALK;
            ST_WALK:  if (fill_valid_i) state_d = ST_RETRY;
            ST_RETRY: state_d = hit_ok ? ST_IDLE : ST_WALK;
            default:  state_d = ST_IDLE;
        endcase
    end

    // output and request-holding registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_vpn_q  <= '0;
            hold_wr_q   <= 1'b0;
            rsp_valid_q <= 1'b0;
            rsp_ppn_q   <= '0;
            rsp_perm_q  <= '0;
        end else begin
            if (accept) begin
                hold_vpn_q <= req_vpn_i;
                hold_wr_q  <= req_write_i;
            end
            rsp_valid_q <= do_lookup && hit_ok;
            if (do_lookup && hit_ok) begin
                rsp_ppn_q  <= ppn_q[m_idx];
                rsp_perm_q <= sel_perm;
            end
        end
    end

    assign req_ready_o = (state_q == ST_IDLE);
    assign fill_req_o  = (state_q == ST_WALK);
    assign fill_vpn_o  = hold_vpn_q;
    assign rsp_valid_o = rsp_valid_q;
    assign rsp_ppn_o   = rsp_ppn_q;
    assign rsp_perm_o  = rsp_perm_q;

    // R3
    fill_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_req_o && !fill_valid_i |=> fill_req_o && $stable(fill_vpn_o));

    // R7
    flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> valid_vec == '0);

    // R5
    one_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(m_vec));

    // R4
    rsp_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_o |-> $past(req_valid_i && req_ready_o) || $past(state_q == ST_RETRY));

endmodule

// File: tb/xlat_buf_test.sv
`timescale 1ns/1ps
module xlat_buf_test;

    localparam int N  = 4;
    localparam int VW = 6;
    localparam int PW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid_i = 1'b0;
    logic [VW-1:0] req_vpn_i = '0;
    logic          req_write_i = 1'b0;
    logic          req_ready_o;
    logic          rsp_valid_o;
    logic [PW-1:0] rsp_ppn_o;
    logic [3:0]    rsp_perm_o;
    logic          fill_req_o;
    logic [VW-1:0] fill_vpn_o;
    logic          fill_valid_i = 1'b0;
    logic [PW-1:0] fill_ppn_i = '0;
    logic [3:0]    fill_perm_i = '0;
    logic          flush_i = 1'b0;
    logic          inv_valid_i = 1'b0;
    logic [VW-1:0] inv_vpn_i = '0;

    always #2.5 clk = ~clk;

    xlat_buf #(.ENTRIES(N), .VPN_W(VW), .PPN_W(PW)) uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid_i(req_valid_i), .req_vpn_i(req_vpn_i), .req_write_i(req_write_i),
        .req_ready_o(req_ready_o),
        .rsp_valid_o(rsp_valid_o), .rsp_ppn_o(rsp_ppn_o), .rsp_perm_o(rsp_perm_o),
        .fill_req_o(fill_req_o), .fill_vpn_o(fill_vpn_o),
        .fill_valid_i(fill_valid_i), .fill_ppn_i(fill_ppn_i), .fill_perm_i(fill_perm_i),
        .flush_i(flush_i), .inv_valid_i(inv_valid_i), .inv_vpn_i(inv_vpn_i)
    );

    int errors = 0;
    int checks = 0;

    // reference model: per-slot state with last-use timestamps
    logic          m_v    [N];
    logic [VW-1:0] m_tag  [N];
    logic [PW-1:0] m_ppn  [N];
    logic [3:0]    m_perm [N];
    int            m_last [N];
    int            now = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [PW-1:0] ppn_of(input logic [VW-1:0] v);
        return PW'(v * 37 + 11);
    endfunction

    // bit0 read=1, bit1 write=v[0], bit2 exec=v[1], bit3 dirty = store ? 1 : v[2]
    function automatic logic [3:0] perm_of(input logic [VW-1:0] v, input bit wr);
        return {wr ? 1'b1 : v[2], v[1], v[0], 1'b1};
    endfunction

    function automatic int find(input logic [VW-1:0] v);
        for (int i = 0; i < N; i++) if (m_v[i] && m_tag[i] == v) return i;
        return -1;
    endfunction

    function automatic int pick(input logic [VW-1:0] v);
        int s, best;
        s = find(v);
        if (s >= 0) return s;
        for (int i = 0; i < N; i++) if (!m_v[i]) return i;
        best = 0;
        for (int i = 1; i < N; i++) if (m_last[i] < m_last[best]) best = i;
        return best;
    endfunction

    task automatic model_install(input logic [VW-1:0] v, input bit wr);
        int s;
        s = pick(v);
        m_v[s] = 1'b1; m_tag[s] = v; m_ppn[s] = ppn_of(v);
        m_perm[s] = perm_of(v, wr); m_last[s] = now; now++;
    endtask

    task automatic model_flush();
        for (int i = 0; i < N; i++) m_v[i] = 1'b0;
    endtask

    task automatic model_inv(input logic [VW-1:0] v);
        for (int i = 0; i < N; i++) if (m_tag[i] == v) m_v[i] = 1'b0;
    endtask

    // disturb: 0 none, 1 flush with first reply, 2 invalidate same page with first reply
    task automatic lookup(input logic [VW-1:0] v, input bit wr, input int disturb, input string req);
        int  s, fills, cyc, exp_fills;
        bit  got, exp_hit;
        s = find(v);
        exp_hit = (s >= 0) && !(wr && !m_perm[s][3]);
        exp_fills = exp_hit ? 0 : ((disturb != 0) ? 2 : 1);
        @(negedge clk);
        while (!req_ready_o) @(negedge clk);
        req_valid_i = 1'b1; req_vpn_i = v; req_write_i = wr;
        @(negedge clk);
        req_valid_i = 1'b0;
        if (exp_hit) begin m_last[s] = now; now++; end
        fills = 0; got = 1'b0; cyc = 0;
        for (int c = 0; c < 20 && !got; c++) begin
            if (rsp_valid_o) begin
                got = 1'b1; cyc = c;
            end else begin
                if (fill_req_o) begin
                    chk(fill_vpn_o == v, "R3 walk page", int'(fill_vpn_o), int'(v));
                    fill_valid_i = 1'b1; fill_ppn_i = ppn_of(v); fill_perm_i = perm_of(v, wr);
                    model_install(v, wr);
                    if (fills == 0 && disturb == 1) begin flush_i = 1'b1; model_flush(); end
                    if (fills == 0 && disturb == 2) begin
                        inv_valid_i = 1'b1; inv_vpn_i = v; model_inv(v);
                    end
                    fills++;
                end
                @(negedge clk);
                fill_valid_i = 1'b0; flush_i = 1'b0; inv_valid_i = 1'b0;
            end
        end
        chk(got, req, 0, 1);
        chk(fills == exp_fills, req, fills, exp_fills);
        chk(cyc == 2 * exp_fills, {req, " latency"}, cyc, 2 * exp_fills);
        s = find(v);
        if (s >= 0) begin
            chk(rsp_ppn_o == m_ppn[s], {req, " ppn"}, int'(rsp_ppn_o), int'(m_ppn[s]));
            chk(rsp_perm_o == m_perm[s], {req, " perm"}, int'(rsp_perm_o), int'(m_perm[s]));
        end
    endtask

    task automatic do_flush();
        @(negedge clk);
        while (!req_ready_o) @(negedge clk);
        flush_i = 1'b1;
        @(negedge clk);
        flush_i = 1'b0;
        model_flush();
    endtask

    task automatic do_inv(input logic [VW-1:0] v);
        @(negedge clk);
        while (!req_ready_o) @(negedge clk);
        inv_valid_i = 1'b1; inv_vpn_i = v;
        @(negedge clk);
        inv_valid_i = 1'b0;
        model_inv(v);
    endtask

    initial begin
        #500000;
        errors++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) begin m_v[i] = 1'b0; m_tag[i] = '0; m_last[i] = -1 - i; end
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(req_ready_o == 1'b1, "R1 ready", int'(req_ready_o), 1);
        chk(fill_req_o == 1'b0, "R1 walk", int'(fill_req_o), 0);
        chk(rsp_valid_o == 1'b0, "R1 rsp", int'(rsp_valid_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready_o == 1'b1 && fill_req_o == 1'b0, "R1 after release", int'(fill_req_o), 0);

        // R1 R3 R4: cold misses fill the buffer
        for (int v = 0; v < N; v++) lookup(VW'(v), 1'b0, 0, "R4 cold miss");
        // R2 hits on every page
        for (int v = 0; v < N; v++) lookup(VW'(v), 1'b0, 0, "R2 hit");

        // R5 store to clean page 0 misses and overwrites in place; others stay
        lookup(VW'(0), 1'b1, 0, "R5 store clean");
        for (int v = 1; v < N; v++) lookup(VW'(v), 1'b0, 0, "R5 no eviction");
        lookup(VW'(0), 1'b1, 0, "R5 store dirty hit");

        // R6 LRU: page 1 is now oldest, page 8 must evict it
        lookup(VW'(8), 1'b0, 0, "R6 evict oldest");
        lookup(VW'(0), 1'b0, 0, "R6 kept");
        lookup(VW'(1), 1'b0, 0, "R6 evicted");

        // R7 flush
        do_flush();
        for (int v = 0; v < 2; v++) lookup(VW'(v), 1'b0, 0, "R7 after flush");

        // R8 single invalidate
        lookup(VW'(2), 1'b0, 0, "R8 setup");
        do_inv(VW'(1));
        lookup(VW'(0), 1'b0, 0, "R8 other kept");
        lookup(VW'(2), 1'b0, 0, "R8 other kept");
        lookup(VW'(1), 1'b0, 0, "R8 removed");

        // R9 races with the reply
        lookup(VW'(20), 1'b0, 1, "R9 flush wins");
        lookup(VW'(21), 1'b1, 2, "R9 inv wins");
        lookup(VW'(21), 1'b0, 0, "R9 refilled");

        // near-exhaustive sweep over eight pages
        for (int i = 0; i < 600; i++) begin
            logic [VW-1:0] v;
            v = VW'((i * 5 + i / 7) % 8);
            if (i % 37 == 36) do_flush();
            if (i % 11 == 10) do_inv(VW'(i % 8));
            lookup(v, (i % 3) == 0, (i % 29 == 28) ? (1 + i % 2) : 0,
                   (i % 3 == 0) ? "R5 sweep" : "R6 sweep");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule